// File: doc/BRIEF.md
# Bundle Template Dispatcher

The block takes wide instruction bundles, up to two per cycle, and turns them into in-order issue groups for a set of typed execution ports. Every bundle is 128 bits wide: a 5-bit template plus three 41-bit instruction slots. The template, and not the opcode bits, fixes the unit class of each slot and marks where parallel issue must break. Opcodes are never examined here.

Accepted bundles sit in a two-bundle window. Each cycle a combinational selector walks the pending slots in program order. It stops at a stop mark, at the first slot whose port class is full, or at a bundle carrying a reserved template. It then presents the chosen slots on compacted issue lanes, each with its slot index, unit class, bundle sequence tag and port number. Slots left behind keep their place ahead of any newer bundle. New bundles are accepted only in a cycle in which the window drains completely.

Top module: `bundle_dispatch`

## Requirements
- R1: Bundle layout and template table.
  - Bits [4:0] hold the template, and the slots sit at [45:5] (slot 0), [86:46] (slot 1) and [127:87] (slot 2).
  - Template bits [4:1] select the slot classes, given for slots 0,1,2: 0=M,I,I; 1=M,I,I with a stop after slot 1; 2=M,L,X; 4=M,M,I; 5=M,M,I with a stop after slot 0; 6=M,F,I; 7=M,M,F; 8=M,I,B; 9=M,B,B; 11=B,B,B; 12=M,M,B; 14=M,F,B. Kinds 3, 10, 13 and 15 are reserved.
  - Template bit 0 places a stop after slot 2.
  - The class code on the issue lanes is M=0, I=1, F=2, B=3, L=4, X=5.
- R2: Issued slots appear on lanes 0 upward in program order (older bundle first, then slot 0 to 2). `iss_count` gives the number of them and `iss_valid` has its lowest `iss_count` bits set. Each lane carries the slot's 41-bit body and its slot index.
- R3: A slot that follows a stop never issues in the same cycle as the slot before that stop.
- R4: Port limits per cycle are: at most 2 M; at most 4 of M, I and L together; at most 2 F; at most 3 B.
  - Port numbers: the n-th M in a group takes port n (0,1); the n-th I or L takes port 3-n; the n-th F takes port 4+n; the n-th B takes port 6+n.
  - Issue stops at the first slot that does not fit.
- R5: An L slot and the X slot after it issue together or not at all. The pair uses one integer port, and the X lane reports the L slot's port.
- R6: A bundle with a reserved template issues nothing.
  - When it is the oldest pending bundle, `bad_bundle` is high for that cycle and the whole bundle is dropped.
  - When older slots are still pending, it waits behind them and the group ends before it.
- R7: `in_ready` is high exactly when no pending slot would remain after this cycle's issue and drop. Slots left behind issue before any bundle accepted later.
- R8: With `out_ready` low nothing issues, nothing is dropped, `bad_bundle` stays low and the window is held.
- R9: The tag counter is 0 after reset. Each accepted bundle takes the next tag, with lane 0 of the input before lane 1, and the tag wraps modulo 2^TAG_W.
- R10: After reset the window is empty, `in_ready` is 1 and `iss_count` is 0.
- R11: `in_valid[1]` may only be high together with `in_valid[0]`. Both bundles are then accepted in the same cycle, with `in_bundle0` the older.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Bundle presence per input lane |
| in_bundle0 | input | 128 | Older incoming bundle |
| in_bundle1 | input | 128 | Younger incoming bundle |
| in_ready | output | 1 | Window accepts new bundles this cycle |
| out_ready | input | 1 | Execution side takes an issue group this cycle |
| iss_count | output | 3 | Number of slots issued |
| iss_valid | output | 6 | Thermometer of active issue lanes |
| iss_insn | output | 246 | Slot bodies, 41 bits per lane |
| iss_slot | output | 12 | Slot index within bundle, 2 bits per lane |
| iss_cls | output | 18 | Unit class code, 3 bits per lane |
| iss_tag | output | 6*TAG_W | Bundle sequence tag per lane |
| iss_port | output | 24 | Target port number, 4 bits per lane |
| bad_bundle | output | 1 | Reserved-template bundle dropped this cycle |

## Verification
The properties assume that the younger input lane is never valid alone; a dedicated check states this assumption. The stimulus only ever drives lane patterns of none, the older lane, or both lanes. The remaining properties relate `out_ready`, `in_ready`, `bad_bundle` and the per-lane classes, and they rely on no other input constraint. The stimulus mixes random legal templates with occasional fully random codes that reach the reserved kinds, and it lowers `out_ready` at random. Directed runs force the port limits, the long-immediate pair, both stop forms and reserved templates in both window positions.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int BUNDLE_W = TMPL_W + 3 * SLOT_W;
  localparam int SPB      = 3;
  localparam int NBUND    = 2;
  localparam int NSLOTS   = SPB * NBUND;
  localparam int PORT_W   = 4;

  typedef enum logic [2:0] {
    CLS_M = 3'd0, CLS_I = 3'd1, CLS_F = 3'd2,
    CLS_B = 3'd3, CLS_L = 3'd4, CLS_X = 3'd5
  } slot_cls_e;

  typedef struct packed {
    logic                legal;
    slot_cls_e [SPB-1:0] cls;
    logic [SPB-1:0]      stop;
  } tmpl_info_t;

  // cls[0] is slot 0; stop[j] breaks the group after slot j
  function automatic tmpl_info_t tmpl_lookup(input logic [TMPL_W-1:0] t);
    tmpl_info_t r;
    r.legal = 1'b1;
    r.stop  = {t[0], 2'b00};
    r.cls   = '{CLS_I, CLS_I, CLS_I};
    case (t[4:1])
      4'd0:  r.cls = '{CLS_I, CLS_I, CLS_M};
      4'd1:  begin r.cls = '{CLS_I, CLS_I, CLS_M}; r.stop[1] = 1'b1; end
      4'd2:  r.cls = '{CLS_X, CLS_L, CLS_M};
      4'd4:  r.cls = '{CLS_I, CLS_M, CLS_M};
      4'd5:  begin r.cls = '{CLS_I, CLS_M, CLS_M}; r.stop[0] = 1'b1; end
      4'd6:  r.cls = '{CLS_I, CLS_F, CLS_M};
      4'd7:  r.cls = '{CLS_F, CLS_M, CLS_M};
      4'd8:  r.cls = '{CLS_B, CLS_I, CLS_M};
      4'd9:  r.cls = '{CLS_B, CLS_B, CLS_M};
      4'd11: r.cls = '{CLS_B, CLS_B, CLS_B};
      4'd12: r.cls = '{CLS_B, CLS_M, CLS_M};
      4'd14: r.cls = '{CLS_B, CLS_F, CLS_M};
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmpl_decode.sv
module tmpl_decode
  import bdisp_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle,
  output tmpl_info_t          info,
  output logic [SLOT_W-1:0]   body [SPB]
);
  assign info = tmpl_lookup(bundle[TMPL_W-1:0]);

  for (genvar j = 0; j < SPB; j++) begin : g_slot
    assign body[j] = bundle[TMPL_W + j*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/issue_select.sv
module issue_select
  import bdisp_pkg::*;
#(
  parameter int MEM_PORTS = 2,
  parameter int INT_PORTS = 4,
  parameter int FP_PORTS  = 2,
  parameter int BR_PORTS  = 3
) (
  input  logic              en,
  input  logic [NSLOTS-1:0] pend,
  input  logic [NBUND-1:0]  ill,
  input  slot_cls_e         cls  [NSLOTS],
  input  logic [NSLOTS-1:0] stop,
  output logic [NSLOTS-1:0] issue_mask,
  output logic [NSLOTS-1:0] drop_mask,
  output logic [PORT_W-1:0] port [NSLOTS],
  output logic              bad
);
  localparam int FP_BASE = INT_PORTS;
  localparam int BR_BASE = INT_PORTS + FP_PORTS;

  always_comb begin
    int nm, ni, nf, nb;
    logic blocked, started, fit;
    logic [PORT_W-1:0] last_port;
    issue_mask = '0;
    drop_mask  = '0;
    bad        = 1'b0;
    nm = 0; ni = 0; nf = 0; nb = 0;
    blocked   = ~en;
    started   = 1'b0;
    last_port = '0;
    for (int s = 0; s < NSLOTS; s++) begin
      port[s] = '0;
      fit     = 1'b0;
      if (pend[s] && !blocked) begin
        if (ill[s/SPB]) begin
          if (!started) begin
            drop_mask[(s/SPB)*SPB +: SPB] = '1;
            bad = 1'b1;
          end
          blocked = 1'b1;
        end else begin
          case (cls[s])
            CLS_M: if (nm < MEM_PORTS && nm + ni < INT_PORTS) begin
              fit = 1'b1; port[s] = PORT_W'(nm); nm++;
            end
            CLS_I, CLS_L: if (nm + ni < INT_PORTS) begin
              fit = 1'b1; port[s] = PORT_W'(INT_PORTS - 1 - ni); ni++;
            end
            CLS_F: if (nf < FP_PORTS) begin
              fit = 1'b1; port[s] = PORT_W'(FP_BASE + nf); nf++;
            end
            CLS_B: if (nb < BR_PORTS) begin
              fit = 1'b1; port[s] = PORT_W'(BR_BASE + nb); nb++;
            end
            default: begin
              fit = 1'b1; port[s] = last_port;
            end
          endcase
          if (fit) begin
            issue_mask[s] = 1'b1;
            started       = 1'b1;
            last_port     = port[s];
            if (stop[s]) blocked = 1'b1;
          end else begin
            blocked = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
  import bdisp_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBUND-1:0]         in_valid,
  input  logic [BUNDLE_W-1:0]      in_bundle0,
  input  logic [BUNDLE_W-1:0]      in_bundle1,
  output logic                     in_ready,
  input  logic                     out_ready,
  output logic [2:0]               iss_count,
  output logic [NSLOTS-1:0]        iss_valid,
  output logic [NSLOTS*SLOT_W-1:0] iss_insn,
  output logic [NSLOTS*2-1:0]      iss_slot,
  output logic [NSLOTS*3-1:0]      iss_cls,
  output logic [NSLOTS*TAG_W-1:0]  iss_tag,
  output logic [NSLOTS*PORT_W-1:0] iss_port,
  output logic                     bad_bundle
);
  logic [BUNDLE_W-1:0] in_b     [NBUND];
  tmpl_info_t          in_info  [NBUND];
  logic [SLOT_W-1:0]   in_body  [NBUND][SPB];

  logic [NSLOTS-1:0]   win_pend, pend_nxt, pend_left;
  logic [NBUND-1:0]    win_ill, ill_nxt;
  slot_cls_e           win_cls  [NSLOTS];
  logic [NSLOTS-1:0]   win_stop;
  logic [SLOT_W-1:0]   win_insn [NSLOTS];
  logic [TAG_W-1:0]    win_tag  [NBUND];
  logic [TAG_W-1:0]    next_tag, tag_nxt;

  logic [NSLOTS-1:0]   issue_mask, drop_mask;
  logic [PORT_W-1:0]   slot_port [NSLOTS];
  logic                load;

  assign in_b[0] = in_bundle0;
  assign in_b[1] = in_bundle1;

  for (genvar b = 0; b < NBUND; b++) begin : g_dec
    tmpl_decode u_dec (.bundle(in_b[b]), .info(in_info[b]), .body(in_body[b]));
  end

  issue_select u_sel (
    .en(out_ready), .pend(win_pend), .ill(win_ill), .cls(win_cls),
    .stop(win_stop), .issue_mask(issue_mask), .drop_mask(drop_mask),
    .port(slot_port), .bad(bad_bundle)
  );

  assign pend_left = win_pend & ~issue_mask & ~drop_mask;
  assign in_ready  = ~|pend_left;
  assign load      = in_ready & in_valid[0];

  always_comb begin
    pend_nxt = pend_left;
    ill_nxt  = win_ill;
    tag_nxt  = next_tag;
    if (load) begin
      pend_nxt = {{SPB{in_valid[1]}}, {SPB{1'b1}}};
      ill_nxt  = {~in_info[1].legal & in_valid[1], ~in_info[0].legal};
      tag_nxt  = next_tag + TAG_W'(1) + TAG_W'(in_valid[1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_pend <= '0;
      win_ill  <= '0;
      next_tag <= '0;
    end else begin
      win_pend <= pend_nxt;
      win_ill  <= ill_nxt;
      next_tag <= tag_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int b = 0; b < NBUND; b++) begin
        win_tag[b] <= next_tag + TAG_W'(b);
        for (int j = 0; j < SPB; j++) begin
          win_cls[b*SPB+j]  <= in_info[b].cls[j];
          win_stop[b*SPB+j] <= in_info[b].stop[j];
          win_insn[b*SPB+j] <= in_body[b][j];
        end
      end
    end
  end

  always_comb begin
    int k;
    iss_insn = '0; iss_slot = '0; iss_cls = '0; iss_tag = '0; iss_port = '0;
    iss_valid = '0;
    k = 0;
    for (int s = 0; s < NSLOTS; s++) begin
      if (issue_mask[s]) begin
        iss_valid[k]                   = 1'b1;
        iss_insn[k*SLOT_W +: SLOT_W]   = win_insn[s];
        iss_slot[k*2 +: 2]             = 2'(s % SPB);
        iss_cls[k*3 +: 3]              = win_cls[s];
        iss_tag[k*TAG_W +: TAG_W]      = win_tag[s/SPB];
        iss_port[k*PORT_W +: PORT_W]   = slot_port[s];
        k++;
      end
    end
    iss_count = 3'(k);
  end
endmodule

// File: rtl/bundle_dispatch_chk.sv
module bundle_dispatch_chk
  import bdisp_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [NBUND-1:0]         in_valid,
  input logic                     in_ready,
  input logic                     out_ready,
  input logic [2:0]               iss_count,
  input logic [NSLOTS-1:0]        iss_valid,
  input logic [NSLOTS*3-1:0]      iss_cls,
  input logic                     bad_bundle
);
  int n_m, n_int, n_f, n_b;

  always_comb begin
    n_m = 0; n_int = 0; n_f = 0; n_b = 0;
    for (int k = 0; k < NSLOTS; k++) begin
      if (iss_valid[k]) begin
        case (iss_cls[k*3 +: 3])
          3'd0: begin n_m++; n_int++; end
          3'd1, 3'd4: n_int++;
          3'd2: n_f++;
          3'd3: n_b++;
          default: ;
        endcase
      end
    end
  end

  // R8
  stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (iss_count == 3'd0 && !bad_bundle));

  // R6
  bad_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_bundle |-> iss_count == 3'd0);

  // R4
  port_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_m <= 2 && n_int <= 4 && n_f <= 2 && n_b <= 3));

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) == int'(iss_count));

  // R7
  accept_then_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid[0]) |=> (!in_ready || iss_count != 3'd0 || bad_bundle));

  // R11
  lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[1] |-> in_valid[0]);
endmodule

bind bundle_dispatch bundle_dispatch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .iss_count(iss_count), .iss_valid(iss_valid),
  .iss_cls(iss_cls), .bad_bundle(bad_bundle)
);

// File: tb/bundle_dispatch_tb_top.sv
module bundle_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;

  logic         clk, rst_n, in_ready, out_ready, bad_bundle;
  logic [1:0]   in_valid;
  logic [127:0] in_bundle0, in_bundle1;
  logic [2:0]   iss_count;
  logic [5:0]   iss_valid;
  logic [245:0] iss_insn;
  logic [11:0]  iss_slot;
  logic [17:0]  iss_cls;
  logic [6*TAG_W-1:0] iss_tag;
  logic [23:0]  iss_port;

  bundle_dispatch #(.TAG_W(TAG_W)) dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model of the window
  bit [5:0]    m_pend;
  bit [1:0]    m_ill;
  int          m_cls [6];
  bit [5:0]    m_stop;
  logic [40:0] m_insn [6];
  int          m_tag [2];
  int          m_next;
  bit [5:0]    e_iss, e_drop;
  bit          e_bad;
  int          e_port [6];

  task automatic chk(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_load(int b, logic [127:0] w);
    int k; bit ok; bit [2:0] st;
    k = int'(w[4:1]); ok = 1; st = {w[0], 2'b00};
    // classes per slot as three digits: slot0, slot1, slot2
    case (k)
      0: begin m_cls[b*3]=0; m_cls[b*3+1]=1; m_cls[b*3+2]=1; end
      1: begin m_cls[b*3]=0; m_cls[b*3+1]=1; m_cls[b*3+2]=1; st[1]=1; end
      2: begin m_cls[b*3]=0; m_cls[b*3+1]=4; m_cls[b*3+2]=5; end
      4: begin m_cls[b*3]=0; m_cls[b*3+1]=0; m_cls[b*3+2]=1; end
      5: begin m_cls[b*3]=0; m_cls[b*3+1]=0; m_cls[b*3+2]=1; st[0]=1; end
      6: begin m_cls[b*3]=0; m_cls[b*3+1]=2; m_cls[b*3+2]=1; end
      7: begin m_cls[b*3]=0; m_cls[b*3+1]=0; m_cls[b*3+2]=2; end
      8: begin m_cls[b*3]=0; m_cls[b*3+1]=1; m_cls[b*3+2]=3; end
      9: begin m_cls[b*3]=0; m_cls[b*3+1]=3; m_cls[b*3+2]=3; end
      11: begin m_cls[b*3]=3; m_cls[b*3+1]=3; m_cls[b*3+2]=3; end
      12: begin m_cls[b*3]=0; m_cls[b*3+1]=0; m_cls[b*3+2]=3; end
      14: begin m_cls[b*3]=0; m_cls[b*3+1]=2; m_cls[b*3+2]=3; end
      default: ok = 0;
    endcase
    m_ill[b] = !ok;
    for (int j = 0; j < 3; j++) begin
      m_stop[b*3+j] = st[j];
      m_insn[b*3+j] = w[5 + 41*j +: 41];
    end
  endfunction

  function automatic void predict(bit ordy);
    int mem_used, int_used, fp_used, br_used, pair_port;
    bit halt, any, ok;
    e_iss = 0; e_drop = 0; e_bad = 0;
    mem_used = 0; int_used = 0; fp_used = 0; br_used = 0; pair_port = 0;
    halt = !ordy; any = 0;
    for (int s = 0; s < 6; s++) begin
      e_port[s] = 0;
      if (!halt && m_pend[s]) begin
        if (m_ill[s/3]) begin
          if (!any) begin e_drop |= (6'b000111 << (3*(s/3))); e_bad = 1; end
          halt = 1;
        end else begin
          ok = 0;
          if (m_cls[s] == 0 && mem_used < 2 && int_used < 4) begin
            ok = 1; e_port[s] = mem_used; mem_used++; int_used++;
          end else if ((m_cls[s] == 1 || m_cls[s] == 4) && int_used < 4) begin
            ok = 1; e_port[s] = 3 - (int_used - mem_used); int_used++;
          end else if (m_cls[s] == 2 && fp_used < 2) begin
            ok = 1; e_port[s] = 4 + fp_used; fp_used++;
          end else if (m_cls[s] == 3 && br_used < 3) begin
            ok = 1; e_port[s] = 6 + br_used; br_used++;
          end else if (m_cls[s] == 5) begin
            ok = 1; e_port[s] = pair_port;
          end
          if (ok) begin
            e_iss[s] = 1; any = 1; pair_port = e_port[s];
            if (m_stop[s]) halt = 1;
          end else halt = 1;
        end
      end
    end
  endfunction

  function automatic logic [127:0] mk(logic [4:0] t);
    logic [127:0] w;
    w[4:0] = t;
    for (int j = 0; j < 3; j++) w[5 + 41*j +: 41] = {$urandom, $urandom};
    return w;
  endfunction

  task automatic cyc(bit [1:0] v, logic [4:0] t0, logic [4:0] t1, bit ordy, string req);
    int cnt, k; bit exp_rdy;
    @(negedge clk);
    in_valid = v; in_bundle0 = mk(t0); in_bundle1 = mk(t1); out_ready = ordy;
    #1;
    predict(ordy);
    exp_rdy = ((m_pend & ~e_iss & ~e_drop) == 0);
    cnt = $countones(e_iss);
    chk(req, "issue count", iss_count, cnt);
    chk("R2", "issue lanes", iss_valid, (1 << cnt) - 1);
    chk("R6", "bad_bundle", bad_bundle, e_bad);
    chk("R7", "in_ready", in_ready, exp_rdy);
    k = 0;
    for (int s = 0; s < 6; s++) begin
      if (e_iss[s]) begin
        chk("R2", "lane slot", iss_slot[k*2 +: 2], s % 3);
        chk("R2", "lane body", iss_insn[k*41 +: 41], m_insn[s]);
        chk("R1", "lane class", iss_cls[k*3 +: 3], m_cls[s]);
        chk("R9", "lane tag", iss_tag[k*TAG_W +: TAG_W], m_tag[s/3]);
        chk((m_cls[s] == 5) ? "R5" : "R4", "lane port", iss_port[k*4 +: 4], e_port[s]);
        k++;
      end
    end
    m_pend &= ~(e_iss | e_drop);
    if (exp_rdy && v[0]) begin
      m_pend = v[1] ? 6'h3f : 6'h07;
      model_load(0, in_bundle0);
      model_load(1, in_bundle1);
      if (!v[1]) m_ill[1] = 0;
      m_tag[0] = m_next; m_tag[1] = (m_next + 1) % 16;
      m_next = (m_next + 1 + int'(v[1])) % 16;
    end
  endtask

  task automatic drain(string req, int n);
    for (int i = 0; i < n; i++) cyc(2'b00, 5'd0, 5'd0, 1'b1, req);
  endtask

  function automatic logic [4:0] rand_tmpl();
    int legal_k [12] = '{0, 1, 2, 4, 5, 6, 7, 8, 9, 11, 12, 14};
    if ($urandom_range(7) == 0) return 5'($urandom);
    return {4'(legal_k[$urandom_range(11)]), 1'($urandom)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    m_pend = 0; m_ill = 0; m_stop = 0; m_next = 0; m_tag[0] = 0; m_tag[1] = 0;
    for (int s = 0; s < 6; s++) begin m_cls[s] = 0; m_insn[s] = '0; end
    in_valid = 0; in_bundle0 = '0; in_bundle1 = '0; out_ready = 1; rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "in_ready after reset", in_ready, 1);
    chk("R10", "iss_count after reset", iss_count, 0);
    @(negedge clk); rst_n = 1;

    // M capacity: MMI + MMF
    cyc(2'b11, {4'd4, 1'b0}, {4'd7, 1'b0}, 1, "R4"); drain("R4", 3);
    // B capacity: BBB + BBB
    cyc(2'b11, {4'd11, 1'b0}, {4'd11, 1'b0}, 1, "R4"); drain("R4", 3);
    // long-immediate pair, twice
    cyc(2'b11, {4'd2, 1'b0}, {4'd2, 1'b0}, 1, "R5"); drain("R5", 3);
    // internal stops
    cyc(2'b11, {4'd1, 1'b0}, {4'd5, 1'b0}, 1, "R3"); drain("R3", 4);
    // stop after last slot of older bundle
    cyc(2'b11, {4'd6, 1'b1}, {4'd8, 1'b0}, 1, "R3"); drain("R3", 3);
    // reserved oldest, then reserved behind legal
    cyc(2'b11, {4'd3, 1'b0}, {4'd0, 1'b0}, 1, "R6"); drain("R6", 3);
    cyc(2'b11, {4'd9, 1'b0}, {4'd13, 1'b0}, 1, "R6"); drain("R6", 3);
    // stall holds the window
    cyc(2'b11, {4'd12, 1'b0}, {4'd14, 1'b0}, 1, "R8");
    cyc(2'b00, 5'd0, 5'd0, 0, "R8"); cyc(2'b00, 5'd0, 5'd0, 0, "R8"); drain("R8", 3);
    // single lane accept
    cyc(2'b01, {4'd0, 1'b0}, {4'd3, 1'b0}, 1, "R11"); drain("R11", 2);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(2);
      cyc(sel == 0 ? 2'b00 : (sel == 1 ? 2'b01 : 2'b11), rand_tmpl(), rand_tmpl(),
          $urandom_range(7) != 0, "R7");
    end
    drain("R9", 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule